// File: doc/BRIEF.md
# Stream-to-Memory FIFO Writer

This block is the write half of a FIFO whose storage sits in external memory. It takes words from a valid/ready input stream. Each accepted word becomes one write command and one write-data beat on a memory port. The memory port has two channels. The command channel carries valid, ready, a write-enable and an address. The data channel carries valid, ready and the data word.

An internal pointer controller supplies the write address and counts the FIFO occupancy level. The address is a base offset plus a pointer that wraps after a set number of words, so the stored words cycle through a fixed memory region. The controller takes a one-cycle increment for each accepted word. It takes a decrement from the consumer side each time the reader frees a slot. Input backpressure does not come from a local full flag. It comes from a programmable write threshold: once the level reaches that threshold, the input stalls. It stays stalled until the consumer frees space.

Top module: `stream_mem_writer`

## Requirements
- R1: After reset, `level_o` is 0, `writable_o` is 1, and both `cmd_valid_o` and `wdata_valid_o` are 0.
- R2: The k-th accepted word (counting from 0 since reset) is issued with `cmd_addr_o` = BASE + (k mod DEPTH), and `cmd_we_o` is 1 whenever `cmd_valid_o` is 1.
- R3: A data slot is free when no data beat is pending, or when the pending beat is accepted in the same cycle. `sink_ready_o` is 1 exactly when `writable_o`, `cmd_ready_i` and a free data slot are all true. `cmd_valid_o` is 1 exactly when `sink_valid_i`, `writable_o` and a free data slot are all true. A word is accepted, and its command completes, in a cycle where `sink_valid_i` and `sink_ready_o` are both high.
- R4: `writable_o` is 1 exactly when `level_o` < WR_THRESH. With no consumer decrements, the input accepts WR_THRESH words and then keeps `sink_ready_o` low.
- R5: `level_o` rises by one for each accepted word. It falls by one for each `rd_pop_i` while the level is non-zero. A pop at level 0 is ignored, and an accept together with a pop in the same cycle leaves the level unchanged.
- R6: The data beat of an accepted word appears on `wdata_valid_o`/`wdata_o` in the cycle after its command handshake. It holds stable until `wdata_ready_i` is seen. Data beats follow the order of their commands.
- R7: When the writes wrap, a later word at an address replaces the earlier one. After 32 words fill the region once and 48 further words follow (BASE 8, DEPTH 32), every location holds the last word whose index maps to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sink_valid_i | input | 1 | Input word valid |
| sink_ready_o | output | 1 | Input word accepted when high with valid |
| sink_data_i | input | DATA_W | Input word |
| rd_pop_i | input | 1 | Consumer frees one slot |
| cmd_valid_o | output | 1 | Write command valid |
| cmd_ready_i | input | 1 | Memory accepts command |
| cmd_we_o | output | 1 | Write-enable of command |
| cmd_addr_o | output | ADDR_W | Word address of command |
| wdata_valid_o | output | 1 | Write-data beat valid |
| wdata_ready_i | input | 1 | Memory accepts data beat |
| wdata_o | output | DATA_W | Write-data word |
| level_o | output | LVL_W | Current FIFO occupancy |
| writable_o | output | 1 | Level below write threshold |

## Verification
The bench runs three input patterns:
- A producer that is always valid, with ready memory channels and no consumer. This shows the threshold stall: exactly WR_THRESH words are accepted, and afterwards ready stays low.
- A consumer-only phase, including pops at level zero. This separates correct level decrement from underflow.
- A long run with random producer gaps, random command and data backpressure, and random pops. This exposes ordering, hold-until-ready and slot-reuse faults.

In the random run, addresses wrap past the region end. The final memory contents show whether later words correctly replace earlier ones.

// File: rtl/smw_pkg.sv
package smw_pkg;
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/smw_ptr_ctrl.sv
module smw_ptr_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int BASE      = 8,
  parameter int DEPTH     = 32,
  parameter int WR_THRESH = DEPTH,
  parameter int PTR_W     = 5,
  parameter int LVL_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              writable_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_TH   = LVL_W'(WR_THRESH);

  logic [PTR_W-1:0] wr_ptr_q;
  logic [LVL_W-1:0] level_q;
  logic             pop_eff;

  assign pop_eff = pop_i && (level_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
    end else if (push_i) begin
      wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
    end else if (push_i && !pop_eff) begin
      level_q <= level_q + 1'b1;
    end else if (!push_i && pop_eff) begin
      level_q <= level_q - 1'b1;
    end
  end

  assign addr_o     = ADDR_W'(BASE) + ADDR_W'(wr_ptr_q);
  assign level_o    = level_q;
  assign writable_o = level_q < LVL_TH;
endmodule

// File: rtl/smw_cmd_issue.sv
module smw_cmd_issue (
  input  logic sink_valid_i,
  input  logic writable_i,
  input  logic slot_free_i,
  input  logic cmd_ready_i,
  output logic cmd_valid_o,
  output logic sink_ready_o,
  output logic fire_o
);
  logic can_issue;

  assign can_issue    = writable_i && slot_free_i;
  assign cmd_valid_o  = sink_valid_i && can_issue;
  assign sink_ready_o = can_issue && cmd_ready_i;
  assign fire_o       = cmd_valid_o && cmd_ready_i;
endmodule

// File: rtl/smw_wdata_stage.sv
module smw_wdata_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wdata_ready_i,
  output logic              wdata_valid_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              slot_free_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              drain;

  assign drain       = full_q && wdata_ready_i;
  assign slot_free_o = !full_q || wdata_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
    end else if (push_i) begin
      full_q <= 1'b1;
    end else if (drain) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (push_i) begin
      data_q <= data_i;
    end
  end

  assign wdata_valid_o = full_q;
  assign wdata_o       = data_q;
endmodule

// File: rtl/stream_mem_writer.sv
module stream_mem_writer #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int BASE      = 8,
  parameter int DEPTH     = 32,
  parameter int WR_THRESH = DEPTH,
  parameter int LVL_W     = smw_pkg::cnt_w(WR_THRESH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sink_valid_i,
  output logic              sink_ready_o,
  input  logic [DATA_W-1:0] sink_data_i,
  input  logic              rd_pop_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_we_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              wdata_valid_o,
  input  logic              wdata_ready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              writable_o
);
  localparam int PTR_W = smw_pkg::cnt_w(DEPTH);

  logic fire;
  logic slot_free;

  smw_ptr_ctrl #(
    .ADDR_W(ADDR_W), .BASE(BASE), .DEPTH(DEPTH),
    .WR_THRESH(WR_THRESH), .PTR_W(PTR_W), .LVL_W(LVL_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (fire),
    .pop_i      (rd_pop_i),
    .addr_o     (cmd_addr_o),
    .level_o    (level_o),
    .writable_o (writable_o)
  );

  smw_cmd_issue u_cmd (
    .sink_valid_i (sink_valid_i),
    .writable_i   (writable_o),
    .slot_free_i  (slot_free),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_valid_o  (cmd_valid_o),
    .sink_ready_o (sink_ready_o),
    .fire_o       (fire)
  );

  smw_wdata_stage #(.DATA_W(DATA_W)) u_wdata (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .push_i        (fire),
    .data_i        (sink_data_i),
    .wdata_ready_i (wdata_ready_i),
    .wdata_valid_o (wdata_valid_o),
    .wdata_o       (wdata_o),
    .slot_free_o   (slot_free)
  );

  assign cmd_we_o = 1'b1;
endmodule

// File: rtl/stream_mem_writer_chk.sv
module stream_mem_writer_chk #(
  parameter int DATA_W    = 32,
  parameter int LVL_W     = 6,
  parameter int WR_THRESH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sink_valid_i,
  input logic              sink_ready_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic              cmd_we_o,
  input logic              wdata_valid_o,
  input logic              wdata_ready_i,
  input logic [DATA_W-1:0] wdata_o,
  input logic [LVL_W-1:0]  level_o,
  input logic              writable_o
);
  a_r2_we_on_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_we_o);

  a_r3_ready_needs_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sink_ready_o |-> (!wdata_valid_o || wdata_ready_i));

  a_r4_no_accept_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !writable_o |-> (!sink_ready_o && !cmd_valid_o));

  a_r5_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(WR_THRESH));

  a_r5_level_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (level_o == $past(level_o) || level_o == $past(level_o) + 1'b1
              || level_o + 1'b1 == $past(level_o)));

  a_r6_beat_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sink_valid_i && sink_ready_o) |=> wdata_valid_o);

  a_r6_wdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdata_valid_o && !wdata_ready_i) |=> (wdata_valid_o && $stable(wdata_o)));
endmodule

bind stream_mem_writer stream_mem_writer_chk #(
  .DATA_W(DATA_W), .LVL_W(LVL_W), .WR_THRESH(WR_THRESH)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sink_valid_i  (sink_valid_i),
  .sink_ready_o  (sink_ready_o),
  .cmd_valid_o   (cmd_valid_o),
  .cmd_ready_i   (cmd_ready_i),
  .cmd_we_o      (cmd_we_o),
  .wdata_valid_o (wdata_valid_o),
  .wdata_ready_i (wdata_ready_i),
  .wdata_o       (wdata_o),
  .level_o       (level_o),
  .writable_o    (writable_o)
);

// File: tb/stream_mem_writer_tb.sv
`timescale 1ns/1ps
module stream_mem_writer_tb;
  localparam int DW = 32, AW = 32, BASE = 8, DEPTH = 32, TH = 32;
  localparam int LW = smw_pkg::cnt_w(TH + 1);
  localparam int TOTAL = 80;

  logic clk_i = 0, rst_ni = 0;
  logic sink_valid_i = 0, rd_pop_i = 0, cmd_ready_i = 0, wdata_ready_i = 0;
  logic [DW-1:0] sink_data_i = '0;
  logic sink_ready_o, cmd_valid_o, cmd_we_o, wdata_valid_o, writable_o;
  logic [AW-1:0] cmd_addr_o;
  logic [DW-1:0] wdata_o;
  logic [LW-1:0] level_o;

  always #2.5 clk_i = ~clk_i;

  stream_mem_writer #(.DATA_W(DW), .ADDR_W(AW), .BASE(BASE), .DEPTH(DEPTH), .WR_THRESH(TH)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sink_valid_i(sink_valid_i), .sink_ready_o(sink_ready_o),
    .sink_data_i(sink_data_i), .rd_pop_i(rd_pop_i), .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i), .cmd_we_o(cmd_we_o), .cmd_addr_o(cmd_addr_o),
    .wdata_valid_o(wdata_valid_o), .wdata_ready_i(wdata_ready_i), .wdata_o(wdata_o),
    .level_o(level_o), .writable_o(writable_o));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_level = 0, m_k = 0;
  logic [DW-1:0] m_pend[$];
  int addr_q[$];
  logic [DW-1:0] mem[int];
  logic pv = 0;
  logic [DW-1:0] pd = '0;

  function automatic logic [DW-1:0] word(int k);
    return 32'hA000_0000 + DW'(k);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(int cycles, int vp, int cp, int wp, int pp);
    for (int c = 0; c < cycles; c++) begin
      bit exp_rdy, exp_cv, fire, drain, pop_eff, slot;
      @(negedge clk_i);
      if (!pv && m_k < TOTAL && ($urandom % 100) < vp) begin
        pv = 1; pd = word(m_k);
      end
      sink_valid_i  = pv;
      sink_data_i   = pd;
      cmd_ready_i   = ($urandom % 100) < cp;
      wdata_ready_i = ($urandom % 100) < wp;
      rd_pop_i      = ($urandom % 100) < pp;
      #1;
      slot    = (m_pend.size() == 0) || wdata_ready_i;
      exp_rdy = (m_level < TH) && cmd_ready_i && slot;
      exp_cv  = pv && (m_level < TH) && slot;
      chk(sink_ready_o == exp_rdy, "R3", "sink_ready", sink_ready_o, exp_rdy);
      chk(cmd_valid_o == exp_cv, "R3", "cmd_valid", cmd_valid_o, exp_cv);
      chk(writable_o == (m_level < TH), "R4", "writable", writable_o, m_level < TH);
      chk(int'(level_o) == m_level, "R5", "level", level_o, m_level);
      if (exp_cv) begin
        chk(cmd_addr_o == AW'(BASE + m_k % DEPTH), "R2", "cmd_addr", cmd_addr_o, BASE + m_k % DEPTH);
        chk(cmd_we_o == 1'b1, "R2", "cmd_we", cmd_we_o, 1);
      end
      chk(wdata_valid_o == (m_pend.size() != 0), "R6", "wdata_valid", wdata_valid_o, m_pend.size() != 0);
      if (m_pend.size() != 0)
        chk(wdata_o == m_pend[0], "R6", "wdata", wdata_o, m_pend[0]);
      // memory model fed from port handshakes
      if (cmd_valid_o && cmd_ready_i) addr_q.push_back(int'(cmd_addr_o));
      if (wdata_valid_o && wdata_ready_i && addr_q.size() != 0) mem[addr_q.pop_front()] = wdata_o;
      fire    = pv && exp_rdy;
      drain   = (m_pend.size() != 0) && wdata_ready_i;
      pop_eff = rd_pop_i && m_level > 0;
      if (drain) void'(m_pend.pop_front());
      if (fire) begin m_pend.push_back(pd); m_k++; pv = 0; end
      m_level += int'(fire) - int'(pop_eff);
    end
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1;
    @(negedge clk_i); #1;
    // R1 reset state
    chk(level_o == 0, "R1", "level", level_o, 0);
    chk(writable_o == 1, "R1", "writable", writable_o, 1);
    chk(cmd_valid_o == 0, "R1", "cmd_valid", cmd_valid_o, 0);
    chk(wdata_valid_o == 0, "R1", "wdata_valid", wdata_valid_o, 0);
    // R4 threshold stall with no consumer
    run(80, 100, 100, 100, 0);
    chk(m_k == TH, "R4", "words before stall", m_k, TH);
    chk(sink_ready_o == 0, "R4", "stalled ready", sink_ready_o, 0);
    // R5 drain, extra pops at zero ignored
    run(45, 0, 100, 100, 100);
    chk(level_o == 0, "R5", "level after drain", level_o, 0);
    // R6 / R7 random traffic with wrap
    run(3000, 60, 70, 70, 50);
    run(300, 0, 100, 100, 100);
    chk(m_k == TOTAL, "R7", "words accepted", m_k, TOTAL);
    for (int a = 0; a < DEPTH; a++) begin
      int last_k = -1;
      for (int k = 0; k < TOTAL; k++) if (k % DEPTH == a) last_k = k;
      chk(mem.exists(BASE + a) && mem[BASE + a] == word(last_k), "R7", "mem word",
          mem.exists(BASE + a) ? mem[BASE + a] : -1, word(last_k));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule